// File: doc/BRIEF.md
# Delayed-Write Parity Error Handler

This block covers the parity error handling for one forwarding direction of a bus-to-bus bridge that carries delayed write transactions. On the target bus it watches the parity error indication while queued write data is delivered. It records a status flag and an interrupt flag, and it latches an error completion status that is later handed back to the initiator.

On the initiating bus, each retried completion attempt is registered and then evaluated in the next clock against the single queued completion entry. The block decides whether to claim the cycle, claim it and raise a delayed parity-error pulse, or answer with a retry. It also reports whether the queue entry is released, kept or discarded.

A programmable discard timer removes an entry that is never collected. Inputs are simplified one-cycle bus event strobes and configuration bits. The bus protocol, address decode and the data storage sit outside the block.

Top module: `dw_parity_guard`

## Requirements
- R1: A cycle with `tgt_xfer` and `tgt_perr` both high sets `flags[0]` (target data parity error) on the next clock when `cfg_tgt_resp_en` is 1. When `cfg_tgt_resp_en` is 0 the flag is left unchanged.
- R2: The same event also sets `flags[2]` (master parity interrupt) when `cfg_mask_mpe` is 0. `flags[2]` is never set without `flags[0]`.
- R3: If `tgt_xfer && tgt_perr` is seen in any cycle since the previous `cpl_load`, including the load cycle itself, `cpl_err_sts` is 1 from the clock after `cpl_load`. Otherwise `cpl_err_sts` is 0 from that clock.
- R4: A data parity error on an attempt is defined as the XOR of `ini_ad`, `ini_cbe` and `ini_par` being 1 (even parity). An attempt whose `ini_par` equals the stored request parity, and that has such an error while `cfg_ini_resp_en` is 1, behaves as follows. It gives a one-cycle `trdy_req` two clocks after the attempt strobe, then a one-cycle `perr_req` exactly two clocks after `trdy_req`. The entry stays valid.
- R5: The same matching attempt with a data parity error while `cfg_ini_resp_en` is 0 gives `retry_req` and `enq_block` two clocks after the strobe. There is no `trdy_req` and no `perr_req`, and the entry stays valid.
- R6: An attempt whose `ini_par` differs from the stored request parity gives `retry_req` only. There is no `enq_block`, and the entry stays valid whatever the data parity.
- R7: A matching attempt without a data parity error gives `trdy_req` and `entry_release` two clocks after the strobe. `entry_valid` is 0 from that clock.
- R8: An attempt while no entry is valid gives `retry_req`. `trdy_req` and `retry_req` are never high together.
- R9: `fwd_bad_par` sets `flags[1]` (detected parity error) when `cfg_ini_resp_en` is 0, and sets `flags[3]` as well when `cfg_mask_dpe` is 0. It is ignored when `cfg_ini_resp_en` is 1.
- R10: A flag bit stays set until a clock where its `flag_clr` bit is 1. If a set and a clear of the same bit fall in one clock, the bit ends up set.
- R11: After `cpl_load`, `entry_valid` stays high for exactly `TMO_CLKS` clocks if no delivery happens. It then drops, with a one-cycle `entry_discard` in the clock it drops. A delivery evaluated in the last valid clock wins: the result is release, not discard.
- R12: Parity-error events on consecutive clocks each produce their own `perr_req` pulse, in consecutive clocks, with none merged or dropped.
- R13: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tgt_resp_en | input | 1 | Parity response enable for the target bus |
| cfg_ini_resp_en | input | 1 | Parity response enable for the initiating bus |
| cfg_mask_mpe | input | 1 | Mask for the master parity interrupt flag |
| cfg_mask_dpe | input | 1 | Mask for the detected parity interrupt flag |
| tgt_xfer | input | 1 | Queued write data is being delivered on the target bus |
| tgt_perr | input | 1 | Parity error indication sampled on the target bus |
| cpl_load | input | 1 | A delayed completion is entered into the queue |
| cpl_req_par | input | 1 | Parity bit of the original request, stored on load |
| ini_try | input | 1 | Completion attempt strobe on the initiating bus |
| ini_ad | input | DATA_W | Address/data of the attempt |
| ini_cbe | input | BE_W | Command/byte enables of the attempt |
| ini_par | input | 1 | Parity bit driven with the attempt |
| fwd_bad_par | input | 1 | A transaction with bad parity was forwarded onward |
| flag_clr | input | 4 | Write-one-to-clear strobes for the flags |
| trdy_req | output | 1 | Request to claim the attempt |
| perr_req | output | 1 | Request to drive the parity error signal |
| retry_req | output | 1 | Request to answer the attempt with a retry |
| enq_block | output | 1 | Do not enqueue the retried transaction |
| entry_valid | output | 1 | Queue entry present |
| entry_release | output | 1 | Entry was delivered and freed |
| entry_discard | output | 1 | Entry timed out and was dropped |
| cpl_err_sts | output | 1 | Completion status is an error |
| flags | output | 4 | Sticky flags: 0 target data parity, 1 detected parity, 2 master parity interrupt, 3 detected parity interrupt |

## Verification
Two pairs of functions can land in the same clock. The first is a flag being set by a bus event while software clears it. The bench drives the target parity event together with an all-ones `flag_clr`, then expects the status and interrupt bits to read as set. The second is the discard timer expiring while a matching clean attempt is evaluated. The bench places the attempt strobe one clock before the final valid clock. It then expects `trdy_req` and `entry_release` with no `entry_discard`.

// File: rtl/dwpg_pkg.sv
package dwpg_pkg;
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_CLAIM = 2'd1,
      ACT_RETRY = 2'd2
   } act_e;

   localparam int NUM_FLAGS    = 4;
   localparam int FLAG_STS_TGT = 0;
   localparam int FLAG_STS_FWD = 1;
   localparam int FLAG_IRQ_TGT = 2;
   localparam int FLAG_IRQ_FWD = 3;
endpackage

// File: rtl/dwpg_flags.sv
module dwpg_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q_o[i] <= 1'b0;
         else if (set_i[i])  q_o[i] <= 1'b1;   // set has priority over clear
         else if (clr_i[i])  q_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/dwpg_entry.sv
module dwpg_entry #(
   parameter int TMO_CLKS = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic load_par_i,
   input  logic tgt_err_i,
   input  logic deliver_i,
   output logic valid_o,
   output logic par_o,
   output logic cpl_err_o,
   output logic release_o,
   output logic discard_o
);
   localparam int CNT_W = (TMO_CLKS > 2) ? $clog2(TMO_CLKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CLKS - 1);

   logic [CNT_W-1:0] age;
   logic             err_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o   <= 1'b0;
         par_o     <= 1'b0;
         cpl_err_o <= 1'b0;
         release_o <= 1'b0;
         discard_o <= 1'b0;
         age       <= '0;
         err_acc   <= 1'b0;
      end else begin
         release_o <= 1'b0;
         discard_o <= 1'b0;
         if (load_i) begin
            valid_o   <= 1'b1;
            par_o     <= load_par_i;
            cpl_err_o <= err_acc | tgt_err_i;
            err_acc   <= 1'b0;
            age       <= '0;
         end else begin
            if (tgt_err_i) err_acc <= 1'b1;
            if (valid_o) begin
               if (deliver_i) begin
                  valid_o   <= 1'b0;
                  release_o <= 1'b1;
                  age       <= '0;
               end else if (age == LAST) begin
                  valid_o   <= 1'b0;
                  discard_o <= 1'b1;
                  age       <= '0;
               end else begin
                  age <= age + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dwpg_attempt.sv
module dwpg_attempt
   import dwpg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int BE_W     = 4,
   parameter int PERR_DLY = 2,
   parameter bit EVEN_PAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              try_i,
   input  logic [DATA_W-1:0] ad_i,
   input  logic [BE_W-1:0]   cbe_i,
   input  logic              par_i,
   input  logic              entry_valid_i,
   input  logic              entry_par_i,
   input  logic              resp_en_i,
   output logic              deliver_o,
   output logic              trdy_o,
   output logic              retry_o,
   output logic              block_o,
   output logic              perr_o
);
   localparam int LINE = PERR_DLY + 1;

   logic raw_odd, bad_now;
   assign raw_odd = ^{ad_i, cbe_i, par_i};

   if (EVEN_PAR) begin : g_even
      assign bad_now = raw_odd;
   end else begin : g_odd
      assign bad_now = ~raw_odd;
   end

   logic s_vld, s_bad, s_par;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_vld <= 1'b0;
         s_bad <= 1'b0;
         s_par <= 1'b0;
      end else begin
         s_vld <= try_i;
         s_bad <= bad_now;
         s_par <= par_i;
      end
   end

   act_e act;
   logic perr_evt, blk;
   always_comb begin
      act       = ACT_NONE;
      perr_evt  = 1'b0;
      blk       = 1'b0;
      deliver_o = 1'b0;
      if (s_vld) begin
         if (!entry_valid_i || (s_par != entry_par_i)) begin
            act = ACT_RETRY;
         end else if (!s_bad) begin
            act       = ACT_CLAIM;
            deliver_o = 1'b1;
         end else if (resp_en_i) begin
            act      = ACT_CLAIM;
            perr_evt = 1'b1;
         end else begin
            act = ACT_RETRY;
            blk = 1'b1;
         end
      end
   end

   logic [LINE-1:0] line;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trdy_o  <= 1'b0;
         retry_o <= 1'b0;
         block_o <= 1'b0;
         line    <= '0;
      end else begin
         trdy_o  <= (act == ACT_CLAIM);
         retry_o <= (act == ACT_RETRY);
         block_o <= blk;
         line    <= {line[LINE-2:0], perr_evt};
      end
   end
   assign perr_o = line[LINE-1];
endmodule

// File: rtl/dw_parity_guard.sv
module dw_parity_guard
   import dwpg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int BE_W     = 4,
   parameter int TMO_CLKS = 32768,
   parameter int PERR_DLY = 2,
   parameter bit EVEN_PAR = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_tgt_resp_en,
   input  logic                 cfg_ini_resp_en,
   input  logic                 cfg_mask_mpe,
   input  logic                 cfg_mask_dpe,
   input  logic                 tgt_xfer,
   input  logic                 tgt_perr,
   input  logic                 cpl_load,
   input  logic                 cpl_req_par,
   input  logic                 ini_try,
   input  logic [DATA_W-1:0]    ini_ad,
   input  logic [BE_W-1:0]      ini_cbe,
   input  logic                 ini_par,
   input  logic                 fwd_bad_par,
   input  logic [NUM_FLAGS-1:0] flag_clr,
   output logic                 trdy_req,
   output logic                 perr_req,
   output logic                 retry_req,
   output logic                 enq_block,
   output logic                 entry_valid,
   output logic                 entry_release,
   output logic                 entry_discard,
   output logic                 cpl_err_sts,
   output logic [NUM_FLAGS-1:0] flags
);
   if (DATA_W < 1)   begin : g_bad_dw  $error("DATA_W must be at least 1");   end
   if (BE_W < 1)     begin : g_bad_be  $error("BE_W must be at least 1");     end
   if (PERR_DLY < 1) begin : g_bad_dly $error("PERR_DLY must be at least 1"); end
   if (TMO_CLKS < 2) begin : g_bad_tmo $error("TMO_CLKS must be at least 2"); end

   logic tgt_hit, deliver, stored_par;
   logic [NUM_FLAGS-1:0] flag_set;

   assign tgt_hit = tgt_xfer & tgt_perr;

   always_comb begin
      flag_set               = '0;
      flag_set[FLAG_STS_TGT] = tgt_hit & cfg_tgt_resp_en;
      flag_set[FLAG_STS_FWD] = fwd_bad_par & ~cfg_ini_resp_en;
      flag_set[FLAG_IRQ_TGT] = flag_set[FLAG_STS_TGT] & ~cfg_mask_mpe;
      flag_set[FLAG_IRQ_FWD] = flag_set[FLAG_STS_FWD] & ~cfg_mask_dpe;
   end

   dwpg_flags #(.N(NUM_FLAGS)) flags_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set),
      .clr_i (flag_clr),
      .q_o   (flags)
   );

   dwpg_entry #(.TMO_CLKS(TMO_CLKS)) entry_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cpl_load),
      .load_par_i (cpl_req_par),
      .tgt_err_i  (tgt_hit),
      .deliver_i  (deliver),
      .valid_o    (entry_valid),
      .par_o      (stored_par),
      .cpl_err_o  (cpl_err_sts),
      .release_o  (entry_release),
      .discard_o  (entry_discard)
   );

   dwpg_attempt #(
      .DATA_W   (DATA_W),
      .BE_W     (BE_W),
      .PERR_DLY (PERR_DLY),
      .EVEN_PAR (EVEN_PAR)
   ) attempt_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .try_i         (ini_try),
      .ad_i          (ini_ad),
      .cbe_i         (ini_cbe),
      .par_i         (ini_par),
      .entry_valid_i (entry_valid),
      .entry_par_i   (stored_par),
      .resp_en_i     (cfg_ini_resp_en),
      .deliver_o     (deliver),
      .trdy_o        (trdy_req),
      .retry_o       (retry_req),
      .block_o       (enq_block),
      .perr_o        (perr_req)
   );
endmodule

// File: rtl/dwpg_checker.sv
module dwpg_checker
   import dwpg_pkg::*;
#(
   parameter int PERR_DLY = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 trdy_req,
   input logic                 perr_req,
   input logic                 retry_req,
   input logic                 enq_block,
   input logic                 entry_valid,
   input logic                 entry_release,
   input logic                 entry_discard,
   input logic [NUM_FLAGS-1:0] flags,
   input logic [NUM_FLAGS-1:0] flag_clr
);
   if (PERR_DLY == 2) begin : g_dly2
      assert_perr_after_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
         perr_req |-> $past(trdy_req, 2));
   end

   assert_claim_retry_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(trdy_req && retry_req));

   assert_block_needs_retry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      enq_block |-> retry_req);

   assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flags) & ~$past(flag_clr)) & ~flags) == '0);

   assert_discard_closes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      entry_discard |-> (!entry_valid && $past(entry_valid)));

   assert_release_discard_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({entry_release, entry_discard}));

   assert_release_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      entry_release |-> !entry_valid);

   assert_irq_tgt_with_sts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[FLAG_IRQ_TGT]) |-> flags[FLAG_STS_TGT]);

   assert_irq_fwd_with_sts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[FLAG_IRQ_FWD]) |-> flags[FLAG_STS_FWD]);
endmodule

bind dw_parity_guard dwpg_checker #(.PERR_DLY(PERR_DLY)) checker_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .trdy_req      (trdy_req),
   .perr_req      (perr_req),
   .retry_req     (retry_req),
   .enq_block     (enq_block),
   .entry_valid   (entry_valid),
   .entry_release (entry_release),
   .entry_discard (entry_discard),
   .flags         (flags),
   .flag_clr      (flag_clr)
);

// File: tb/dw_parity_guard_tb_top.sv
module dw_parity_guard_tb_top;
   localparam int TMO = 32768;
   localparam logic [31:0] AD_PAT  = 32'hA5A5_0F01;
   localparam logic [3:0]  CBE_PAT = 4'h3;
   // {resp_en, cpl_err, par_mismatch, data_err | trdy, retry, block, perr, release, valid_after}
   localparam logic [9:0] VEC [8] = '{
      10'b1000_100010,
      10'b1001_100101,
      10'b0001_011001,
      10'b1010_010001,
      10'b0011_010001,
      10'b0000_100010,
      10'b1100_100010,
      10'b1101_100101
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_tgt_resp_en = 0, cfg_ini_resp_en = 0, cfg_mask_mpe = 0, cfg_mask_dpe = 0;
   logic tgt_xfer = 0, tgt_perr = 0, cpl_load = 0, cpl_req_par = 0;
   logic ini_try = 0, ini_par = 0, fwd_bad_par = 0;
   logic [31:0] ini_ad = '0;
   logic [3:0]  ini_cbe = '0;
   logic [3:0]  flag_clr = '0;
   logic trdy_req, perr_req, retry_req, enq_block, entry_valid;
   logic entry_release, entry_discard, cpl_err_sts;
   logic [3:0] flags;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dw_parity_guard #(.TMO_CLKS(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_tgt_resp_en(cfg_tgt_resp_en), .cfg_ini_resp_en(cfg_ini_resp_en),
      .cfg_mask_mpe(cfg_mask_mpe), .cfg_mask_dpe(cfg_mask_dpe),
      .tgt_xfer(tgt_xfer), .tgt_perr(tgt_perr),
      .cpl_load(cpl_load), .cpl_req_par(cpl_req_par),
      .ini_try(ini_try), .ini_ad(ini_ad), .ini_cbe(ini_cbe), .ini_par(ini_par),
      .fwd_bad_par(fwd_bad_par), .flag_clr(flag_clr),
      .trdy_req(trdy_req), .perr_req(perr_req), .retry_req(retry_req),
      .enq_block(enq_block), .entry_valid(entry_valid),
      .entry_release(entry_release), .entry_discard(entry_discard),
      .cpl_err_sts(cpl_err_sts), .flags(flags)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic logic good_par();
      return ^{AD_PAT, CBE_PAT};
   endfunction

   task automatic load_entry(input logic p, input logic err);
      cpl_load = 1; cpl_req_par = p; tgt_xfer = err; tgt_perr = err;
      tick();
      cpl_load = 0; tgt_xfer = 0; tgt_perr = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int cnt;
      logic [9:0] w;
      logic apar;
      ini_ad = AD_PAT; ini_cbe = CBE_PAT;
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R13: reset state
      chk("R13 outputs", {trdy_req, perr_req, retry_req, enq_block, entry_valid,
                          entry_release, entry_discard, cpl_err_sts, flags}, 32'h0);

      // R8: attempt with no entry
      ini_try = 1; ini_par = good_par(); tick(); ini_try = 0; tick();
      chk("R8 retry no entry", retry_req, 1);
      chk("R8 no claim", trdy_req, 0);

      // Vector table: R3 R4 R5 R6 R7
      for (int v = 0; v < 8; v++) begin
         w = VEC[v];
         apar = good_par() ^ w[6];
         cfg_ini_resp_en = w[9];
         load_entry(apar ^ w[7], w[8]);
         chk("R3 cpl status", cpl_err_sts, w[8]);
         ini_try = 1; ini_par = apar;
         tick(); ini_try = 0;
         tick();
         chk("R4/R7 trdy", trdy_req, w[5]);
         chk("R5/R6 retry", retry_req, w[4]);
         chk("R5 enq_block", enq_block, w[3]);
         chk("R7 release", entry_release, w[1]);
         tick(); tick();
         chk("R4 perr two after trdy", perr_req, w[2]);
         chk("R4/R5/R6 entry kept", entry_valid, w[0]);
      end

      // R12: back-to-back parity-error claims
      cfg_ini_resp_en = 1;
      apar = good_par() ^ 1'b1;
      load_entry(apar, 0);
      ini_try = 1; ini_par = apar; tick(); tick(); ini_try = 0;
      chk("R12 trdy first", trdy_req, 1);
      chk("R12 no early perr", perr_req, 0);
      tick(); chk("R12 trdy second", trdy_req, 1);
      tick(); chk("R12 perr first", perr_req, 1);
      tick(); chk("R12 perr second", perr_req, 1);
      tick(); chk("R12 perr ends", perr_req, 0);

      // R11: timeout without delivery
      load_entry(good_par(), 0);
      cnt = 0;
      while (entry_valid && cnt < 40000) begin cnt++; tick(); end
      chk("R11 valid window", cnt, TMO);
      chk("R11 discard pulse", entry_discard, 1);
      tick(); chk("R11 discard single", entry_discard, 0);

      // R11: delivery in the final valid clock beats the timeout
      load_entry(good_par(), 0);
      repeat (TMO - 2) tick();
      ini_try = 1; ini_par = good_par(); tick(); ini_try = 0; tick();
      chk("R11 collision trdy", trdy_req, 1);
      chk("R11 collision release", entry_release, 1);
      chk("R11 collision no discard", entry_discard, 0);
      chk("R11 collision entry gone", entry_valid, 0);

      // R1 R2: target-side flags
      flag_clr = 4'hF; tick(); flag_clr = 0;
      cfg_tgt_resp_en = 1; cfg_mask_mpe = 0;
      tgt_xfer = 1; tgt_perr = 1; tick(); tgt_xfer = 0; tgt_perr = 0;
      chk("R1/R2 set status and irq", flags, 4'b0101);
      flag_clr = 4'hF; tick(); flag_clr = 0;
      chk("R10 clear", flags, 4'b0000);
      cfg_mask_mpe = 1;
      tgt_xfer = 1; tgt_perr = 1; tick(); tgt_xfer = 0; tgt_perr = 0;
      chk("R2 masked irq", flags, 4'b0001);
      flag_clr = 4'hF; tick(); flag_clr = 0;
      cfg_tgt_resp_en = 0;
      tgt_xfer = 1; tgt_perr = 1; tick(); tgt_xfer = 0; tgt_perr = 0;
      chk("R1 response disabled", flags, 4'b0000);

      // R9: forwarded bad parity
      cfg_ini_resp_en = 0; cfg_mask_dpe = 0;
      fwd_bad_par = 1; tick(); fwd_bad_par = 0;
      chk("R9 set status and irq", flags, 4'b1010);
      flag_clr = 4'hF; tick(); flag_clr = 0;
      cfg_ini_resp_en = 1;
      fwd_bad_par = 1; tick(); fwd_bad_par = 0;
      chk("R9 ignored when enabled", flags, 4'b0000);

      // R10: set wins over clear in one clock, then selective clear
      cfg_tgt_resp_en = 1; cfg_mask_mpe = 0;
      tgt_xfer = 1; tgt_perr = 1; flag_clr = 4'hF; tick();
      tgt_xfer = 0; tgt_perr = 0; flag_clr = 0;
      chk("R10 set wins", flags, 4'b0101);
      flag_clr = 4'b0001; tick(); flag_clr = 0;
      chk("R10 selective clear", flags, 4'b0100);

      finish_run();
   end
endmodule